// File: doc/BRIEF.md
# Timed Self-Programming Command Controller

This block sits between a small CPU core and the non-volatile configuration storage. Software arms a special operation by writing a command pattern into a 7-bit control/status register. The write opens a short window that is counted in clock cycles.

- A store-program strobe that falls inside the window programs lock bits from a data byte.
- A load-program strobe that falls inside the window returns a configuration byte instead of flash data. The address pointer selects the lock byte or the fuse low byte.
- When no strobe arrives, the window closes by itself and the arming bits clear.

The block also keeps a busy flag for the read-while-write flash region and raises an error on loads from that region while the flag is set. While the EEPROM controller reports a write in progress, the block refuses commands.

Top module: `selfprog_cmd_ctrl`

## Requirements
- R1: A control write whose 7 bits equal `0001001` arms the block. In the following cycle, status bits 3 and 0 of `ctrlRdData` read 1. A write of any other value leaves the block unarmed.
- R2: A store strobe in any of the 4 cycles after the arming write updates the lock bits as `lock = lock & lockWrData`. Each zero data bit programs its lock bit. The pointer value has no effect on this.
- R3: If no strobe completes the operation, the arming bits read 0 from the 5th cycle after the arming write onward. A store strobe in that cycle leaves the lock bits unchanged.
- R4: A load strobe in any of the first 3 cycles after the arming write returns configuration data. A load strobe in the 4th cycle returns `flashRdData`.
- R5: During an armed load, the pointer selects the returned byte:
  - pointer 1 returns `{2'b11, lock[5:0]}`;
  - pointer 0 returns the fuse low byte, a parameter;
  - any other pointer returns 8'hFF.
- R6: An accepted store or an accepted load clears the arming bits in the next cycle.
- R7: Any accepted control write restarts the window. A matching write re-arms with a fresh 4-cycle window, and a non-matching write disarms.
- R8: After reset the lock bits are all ones. Through this block they only ever change from 1 to 0.
- R9: While `eeWriteBusy` is high, the block ignores control writes, store strobes and load strobes. An ignored load returns `flashRdData`.
- R10: In every cycle where `pageOpBusy` is high, the read-while-write busy flag (`rwwBusy`, also status bit 6) is set in the next cycle. It stays set until a control write of `0010001` arrives in a cycle with `pageOpBusy` low.
- R11: `rwwReadErr` is high exactly when a load strobe outside a configuration read targets the read-while-write region (`loadInRww`) while the busy flag is set.
- R12: A load strobe outside an armed window returns `flashRdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 7 | Control register write data |
| ctrlRdData | output | 8 | Status: bit 6 rww busy, bits 3 and 0 armed |
| storeStrobe | input | 1 | Store-program instruction executing |
| loadStrobe | input | 1 | Load-program instruction executing |
| lockWrData | input | 6 | Lock data for a store (0 = program) |
| zPtr | input | 16 | Address pointer |
| flashRdData | input | 8 | Normal flash read data |
| loadInRww | input | 1 | Load address lies in the read-while-write region |
| eeWriteBusy | input | 1 | EEPROM write in progress |
| pageOpBusy | input | 1 | Page erase or page write in progress |
| loadData | output | 8 | Data returned to the load |
| lockBits | output | 6 | Current lock bits |
| rwwBusy | output | 1 | Read-while-write region busy flag |
| rwwReadErr | output | 1 | Load from the busy read-while-write region |

## Verification
The bench probes both window edges. It places stores in the 4th and 5th cycles after arming, and loads in the 3rd and 4th. An off-by-one counter would accept a late strobe or drop a legal one, and the lock bits or the load data would then differ. A re-arm in the middle of a window must restart the count; a design that kept the old count would close the window early. Stores and arming writes are issued while the EEPROM is busy, and a design that failed to gate them would change lock bits. A re-enable write is also issued during a page operation, and clearing the busy flag there would silence the read error.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  typedef struct packed {
    logic armed;      // window open
    logic lockWrite;  // accepted store: program lock bits
    logic cfgRead;    // accepted load: return configuration byte
    logic rwwClear;   // re-enable command accepted
  } ctrlStrobe_t;
endpackage

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [6:0]  ctrlWrData,
  input  logic        storeStrobe,
  input  logic        loadStrobe,
  input  logic        eeWriteBusy,
  output ctrlStrobe_t strb
);
  localparam int CNT_W = $clog2(STORE_WIN + 1);
  localparam int LOAD_FLOOR = STORE_WIN - LOAD_WIN;
  localparam logic [6:0] ARM_CODE  = 7'b0001001;
  localparam logic [6:0] REEN_CODE = 7'b0010001;

  logic [CNT_W-1:0] winCnt;
  logic wrOk, armCmd, storeOpen, loadOpen;

  always_comb begin
    wrOk      = ctrlWrEn && !eeWriteBusy;
    armCmd    = wrOk && (ctrlWrData == ARM_CODE);
    storeOpen = (winCnt != '0);
    loadOpen  = (winCnt > CNT_W'(LOAD_FLOOR));
    strb.armed     = storeOpen;
    strb.lockWrite = storeStrobe && storeOpen && !eeWriteBusy;
    strb.cfgRead   = loadStrobe && loadOpen && !eeWriteBusy;
    strb.rwwClear  = wrOk && (ctrlWrData == REEN_CODE);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      winCnt <= '0;
    else if (wrOk)
      winCnt <= armCmd ? CNT_W'(STORE_WIN) : '0;
    else if (strb.lockWrite || strb.cfgRead)
      winCnt <= '0;
    else if (storeOpen)
      winCnt <= winCnt - 1'b1;
  end
endmodule

// File: rtl/selfprog_dp.sv
module selfprog_dp
  import selfprog_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          LOCK_W    = 6,
  parameter logic [7:0]  FUSE_INIT = 8'h62,
  parameter int          LOCK_ADDR = 1,
  parameter int          FUSE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [LOCK_W-1:0] lockWrData,
  input  logic [ADDR_W-1:0] zPtr,
  input  logic [7:0]        flashRdData,
  input  logic              loadStrobe,
  input  logic              loadInRww,
  input  logic              pageOpBusy,
  output logic [7:0]        loadData,
  output logic [7:0]        ctrlRdData,
  output logic [LOCK_W-1:0] lockBits,
  output logic              rwwBusy,
  output logic              rwwReadErr
);
  localparam int PAD_W = 8 - LOCK_W;

  for (genvar i = 0; i < LOCK_W; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rstN)
        lockBits[i] <= 1'b1;
      else if (strb.lockWrite && !lockWrData[i])
        lockBits[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rwwBusy <= 1'b0;
    else if (pageOpBusy)
      rwwBusy <= 1'b1;
    else if (strb.rwwClear)
      rwwBusy <= 1'b0;
  end

  logic [7:0] cfgByte;
  always_comb begin
    if (zPtr == ADDR_W'(LOCK_ADDR))
      cfgByte = {{PAD_W{1'b1}}, lockBits};
    else if (zPtr == ADDR_W'(FUSE_ADDR))
      cfgByte = FUSE_INIT;
    else
      cfgByte = 8'hFF;
    loadData   = strb.cfgRead ? cfgByte : flashRdData;
    rwwReadErr = loadStrobe && loadInRww && rwwBusy && !strb.cfgRead;
    ctrlRdData = {1'b0, rwwBusy, 2'b00, strb.armed, 2'b00, strb.armed};
  end
endmodule

// File: rtl/selfprog_cmd_ctrl.sv
module selfprog_cmd_ctrl
  import selfprog_pkg::*;
#(
  parameter int         STORE_WIN = 4,
  parameter int         LOAD_WIN  = 3,
  parameter int         ADDR_W    = 16,
  parameter int         LOCK_W    = 6,
  parameter logic [7:0] FUSE_INIT = 8'h62
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [6:0]        ctrlWrData,
  output logic [7:0]        ctrlRdData,
  input  logic              storeStrobe,
  input  logic              loadStrobe,
  input  logic [LOCK_W-1:0] lockWrData,
  input  logic [ADDR_W-1:0] zPtr,
  input  logic [7:0]        flashRdData,
  input  logic              loadInRww,
  input  logic              eeWriteBusy,
  input  logic              pageOpBusy,
  output logic [7:0]        loadData,
  output logic [LOCK_W-1:0] lockBits,
  output logic              rwwBusy,
  output logic              rwwReadErr
);
  ctrlStrobe_t strb;

  selfprog_ctrl #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe),
    .eeWriteBusy(eeWriteBusy), .strb(strb)
  );

  selfprog_dp #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .FUSE_INIT(FUSE_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lockWrData(lockWrData),
    .zPtr(zPtr), .flashRdData(flashRdData), .loadStrobe(loadStrobe),
    .loadInRww(loadInRww), .pageOpBusy(pageOpBusy), .loadData(loadData),
    .ctrlRdData(ctrlRdData), .lockBits(lockBits), .rwwBusy(rwwBusy),
    .rwwReadErr(rwwReadErr)
  );
endmodule

// File: rtl/selfprog_cmd_ctrl_chk.sv
module selfprog_cmd_ctrl_chk #(
  parameter int STORE_WIN = 4,
  parameter int LOCK_W    = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic              eeWriteBusy,
  input logic              pageOpBusy,
  input logic [7:0]        ctrlRdData,
  input logic [LOCK_W-1:0] lockBits,
  input logic              rwwBusy,
  input logic              rwwReadErr
);
  int armedRun;
  logic pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedRun  <= 0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (ctrlWrEn && !eeWriteBusy) armedRun <= 0;
      else if (ctrlRdData[0])       armedRun <= armedRun + 1;
      else                          armedRun <= 0;
    end
  end

  // R3: an armed state never outlives its window
  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[0] |-> (armedRun < STORE_WIN));

  // R8: lock bits only go from 1 to 0
  a_r8_lock_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((lockBits & ~$past(lockBits)) == '0));

  // R9: EEPROM write blocks lock programming
  a_r9_ee_blocks_lock: assert property (@(posedge clk) disable iff (!rstN)
    eeWriteBusy |=> $stable(lockBits));

  // R10: page operation sets the busy flag
  a_r10_rww_set: assert property (@(posedge clk) disable iff (!rstN)
    pageOpBusy |=> rwwBusy);

  // R11: read error only while the busy flag is set
  a_r11_err_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    rwwReadErr |-> rwwBusy);

  // R1: arming and enable status bits move together
  a_r1_status_pair: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[3] == ctrlRdData[0]);
endmodule

bind selfprog_cmd_ctrl selfprog_cmd_ctrl_chk #(.STORE_WIN(STORE_WIN), .LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .eeWriteBusy(eeWriteBusy),
  .pageOpBusy(pageOpBusy), .ctrlRdData(ctrlRdData), .lockBits(lockBits),
  .rwwBusy(rwwBusy), .rwwReadErr(rwwReadErr)
);

// File: tb/selfprog_cmd_ctrl_tb.sv
module selfprog_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FUSE = 8'h62;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 0, storeStrobe = 0, loadStrobe = 0, loadInRww = 0;
  logic eeWriteBusy = 0, pageOpBusy = 0;
  logic [6:0] ctrlWrData = '0;
  logic [5:0] lockWrData = '1;
  logic [15:0] zPtr = '0;
  logic [7:0] flashRdData = '0;
  logic [7:0] ctrlRdData, loadData;
  logic [5:0] lockBits;
  logic rwwBusy, rwwReadErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  int mCnt = 0;
  logic [5:0] mLock = 6'h3F;
  logic mRww = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfprog_cmd_ctrl #(.FUSE_INIT(FUSE)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .storeStrobe(storeStrobe), .loadStrobe(loadStrobe),
    .lockWrData(lockWrData), .zPtr(zPtr), .flashRdData(flashRdData),
    .loadInRww(loadInRww), .eeWriteBusy(eeWriteBusy), .pageOpBusy(pageOpBusy),
    .loadData(loadData), .lockBits(lockBits), .rwwBusy(rwwBusy),
    .rwwReadErr(rwwReadErr)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleIn();
    ctrlWrEn = 0; storeStrobe = 0; loadStrobe = 0; loadInRww = 0;
    eeWriteBusy = 0; pageOpBusy = 0; ctrlWrData = '0;
    lockWrData = '1; zPtr = 16'h0001; flashRdData = 8'h5A;
  endtask

  // Compare all outputs against the model, then advance model and clock.
  task automatic tick();
    bit cfgRd, acceptSt, armed;
    logic [7:0] expLoad;
    #1;
    armed    = (mCnt > 0);
    acceptSt = storeStrobe && mCnt > 0 && !eeWriteBusy;
    cfgRd    = loadStrobe && mCnt >= 2 && !eeWriteBusy;
    if (cfgRd)
      expLoad = (zPtr == 16'd1) ? {2'b11, mLock} : (zPtr == 16'd0) ? FUSE : 8'hFF;
    else
      expLoad = flashRdData;
    chk("R4 R5 R12 R9 loadData", loadData, expLoad);
    chk("R1 R3 R6 R7 R10 ctrlRdData", ctrlRdData,
        {1'b0, mRww, 2'b00, armed, 2'b00, armed});
    chk("R2 R8 R9 lockBits", {2'b00, lockBits}, {2'b00, mLock});
    chk("R10 rwwBusy", {7'd0, rwwBusy}, {7'd0, mRww});
    chk("R11 rwwReadErr", {7'd0, rwwReadErr},
        {7'd0, loadStrobe && loadInRww && mRww && !cfgRd});
    if (acceptSt) mLock = mLock & lockWrData;
    if (pageOpBusy) mRww = 1;
    else if (ctrlWrEn && !eeWriteBusy && ctrlWrData == 7'b0010001) mRww = 0;
    if (ctrlWrEn && !eeWriteBusy) mCnt = (ctrlWrData == 7'b0001001) ? 4 : 0;
    else if (acceptSt || cfgRd) mCnt = 0;
    else if (mCnt > 0) mCnt--;
    @(posedge clk);
    @(negedge clk);
    idleIn();
  endtask

  task automatic arm();
    ctrlWrEn = 1; ctrlWrData = 7'b0001001; tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idleIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    idle(1);                                   // R8 reset state
    arm(); storeStrobe = 1; lockWrData = 6'b111110; zPtr = 16'h1234; tick(); // R2 first cycle, pointer ignored
    idle(1);                                   // R6 arming cleared
    arm(); idle(3); storeStrobe = 1; lockWrData = 6'b111101; tick();     // R2 4th cycle
    arm(); idle(4); storeStrobe = 1; lockWrData = 6'b000000; tick();     // R3 5th cycle ignored
    arm(); loadStrobe = 1; zPtr = 16'd1; tick();                         // R5 lock byte
    arm(); idle(2); loadStrobe = 1; zPtr = 16'd0; tick();                // R4 3rd cycle fuse
    arm(); idle(3); loadStrobe = 1; zPtr = 16'd0; tick();                // R4 4th cycle flash
    arm(); loadStrobe = 1; zPtr = 16'd7; tick();                         // R5 other pointer
    loadStrobe = 1; flashRdData = 8'hC3; tick();                         // R12 unarmed load
    arm(); idle(2); arm(); idle(3); storeStrobe = 1; lockWrData = 6'b111011; tick(); // R7 re-arm
    arm(); ctrlWrEn = 1; ctrlWrData = 7'b0001011; tick(); idle(1);       // R7 disarm, R1 wrong code
    ctrlWrEn = 1; ctrlWrData = 7'b0001001; eeWriteBusy = 1; tick(); idle(1); // R9 write ignored
    arm(); eeWriteBusy = 1; storeStrobe = 1; lockWrData = 6'b0; tick();  // R9 store ignored
    eeWriteBusy = 1; loadStrobe = 1; tick();                             // R9 load ignored
    pageOpBusy = 1; tick(); pageOpBusy = 1; tick();                      // R10 set
    pageOpBusy = 1; ctrlWrEn = 1; ctrlWrData = 7'b0010001; tick();       // R10 clear blocked
    loadStrobe = 1; loadInRww = 1; tick();                               // R11 error
    ctrlWrEn = 1; ctrlWrData = 7'b0010001; tick();                       // R10 clear
    loadStrobe = 1; loadInRww = 1; tick();                               // R11 no error
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ctrlWrEn    = (r < 15);
      ctrlWrData  = ($urandom_range(0, 2) == 0) ? 7'($urandom) :
                    ($urandom_range(0, 3) == 0) ? 7'b0010001 : 7'b0001001;
      storeStrobe = ($urandom_range(0, 5) == 0);
      loadStrobe  = ($urandom_range(0, 3) == 0);
      lockWrData  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h3F;
      zPtr        = 16'($urandom_range(0, 2));
      flashRdData = 8'($urandom);
      loadInRww   = $urandom_range(0, 1) == 1;
      eeWriteBusy = ($urandom_range(0, 9) == 0);
      pageOpBusy  = ($urandom_range(0, 19) == 0);
      tick();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule